// File: doc/BRIEF.md
# Two-Buffer Alternating DMA Channel

This block is one DMA channel that alternates between two buffer descriptors. Each descriptor holds a memory start address and a 16-bit item count. Software programs the channel through a 32-bit word register port. The channel's control word has two write addresses: one that sets the bits written as 1 and one that clears them. A channel with its go bit set serves one peripheral request at a time. For each request it moves one item through a single-beat bus master: a read beat from the source, then a write beat to the destination. One end of every item is a fixed peripheral FIFO address and the other is the current memory address of the active buffer.

When the active buffer's count reaches zero, the channel marks that buffer done and withdraws its enable. It then flips the active-buffer bit and goes on with the other buffer if that buffer is enabled. Software can refill one buffer while the other is draining. A level interrupt reports done buffers. A halt status bit tells software when a stopped channel has no bus transfer left in flight, so the buffers can be safely disabled.

The state machine has four states. ST_IDLE waits for work. It moves to ST_SWITCH when the go bit is set, the active buffer is enabled and that buffer's count is zero. It moves to ST_FETCH when the go bit is set, the active buffer is enabled and the peripheral is requesting. ST_SWITCH retires the buffer and always returns to ST_IDLE. ST_FETCH issues the read beat and moves to ST_STORE when the bus acknowledges. ST_STORE issues the write beat and returns to ST_IDLE when the bus acknowledges.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset every register reads 0, except the control word, which reads 0x40 (halt set). bus_req, per_ack and irq are 0.
- R2: Word offsets: 0x00 sets control bits and reads the control word, 0x04 clears control bits, 0x08 holds the FIFO address, 0x0C/0x10 hold buffer 0 address/count and 0x14/0x18 hold buffer 1 address/count. Control bits: 0 enable0, 1 done0, 2 enable1, 3 done1, 4 active buffer, 5 go, 6 halt (read-only), 7 interrupt enable, 8 non-coherent, 10:9 item width (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes), 11 burst-size flag, 12 direction, 13 byte swap, 15 device bank, 19:16 device id. A set or clear write changes only the named writable bits. Bits 6, 14 and 31:20 are never stored.
- R3: Count registers keep bits 15:0 only. Upper bits written are ignored and read as 0.
- R4: Each served request produces a read beat (bus_we = 0) followed by a write beat (bus_we = 1). With direction 1 the read uses the FIFO address and the write uses the buffer address; with direction 0 the two are swapped.
- R5: Each item decrements the active buffer's count by 1. It also advances that buffer's address register by the item width in bytes.
- R6: When the active count is zero, the done bit of that buffer is set, its enable is cleared and the active bit toggles. Service then continues from the other buffer when that buffer is enabled.
- R7: With go set and the active buffer disabled, peripheral requests produce no bus activity. Go stays 1 and halt stays 0.
- R8: irq is 1 exactly while interrupt enable is 1 and at least one done bit is 1.
- R9: Halt reads 1 only while go is 0 and no item is in flight. Clearing go during an item lets that item complete.
- R10: A done bit is removed only by writing 1 to it at the clear address. Zero writes to either address leave it set.
- R11: The written data holds only the item-width low bytes of the read data. With byte swap set, those bytes are written in reversed order.
- R12: per_ack is a one-cycle pulse in the cycle the write beat is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| per_req | input | 1 | Peripheral request level |
| per_ack | output | 1 | Item completed pulse |
| bus_req | output | 1 | Bus beat request, held until acknowledged |
| bus_we | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_addr | output | 32 | Beat byte address |
| bus_wdata | output | 32 | Write beat data |
| bus_rdata | input | 32 | Read beat data, valid with bus_ack |
| bus_ack | input | 1 | Beat acknowledge |
| irq | output | 1 | Done interrupt level |

## Verification
The assertions take for granted that the bus acknowledges only while a beat is requested, and that software does not rewrite a descriptor while the channel is using it. The stimulus raises bus_ack only after it has seen bus_req. It reprograms descriptors only between runs, once every enabled buffer has drained. The bench drops per_req right after each acknowledged item, so one request never counts twice. Random item widths, directions, swap settings, counts and bus delays are drawn inside these limits.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int MB_EN0   = 0;
    localparam int MB_DN0   = 1;
    localparam int MB_EN1   = 2;
    localparam int MB_DN1   = 3;
    localparam int MB_ACT   = 4;
    localparam int MB_GO    = 5;
    localparam int MB_HALT  = 6;
    localparam int MB_IE    = 7;
    localparam int MB_DW_LO = 9;
    localparam int MB_DIR   = 12;
    localparam int MB_SWAP  = 13;

    localparam logic [31:0] MODE_RW_MASK = 32'h000F_BFBF;

    localparam int WI_SET  = 0;
    localparam int WI_CLR  = 1;
    localparam int WI_FIFO = 2;
    localparam int WI_A0   = 3;
    localparam int WI_C0   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SWITCH,
        ST_FETCH,
        ST_STORE
    } dma_state_e;

    function automatic int unsigned item_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/pp_dma_lane.sv
module pp_dma_lane
    import pp_dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        width_code,
    input  logic              swap,
    output logic [DATA_W-1:0] lane
);
    localparam int NBYTES = DATA_W / 8;

    always_comb begin
        int unsigned nb;
        nb   = item_bytes(width_code);
        if (nb > NBYTES) nb = NBYTES;
        lane = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < int'(nb)) begin
                if (swap) lane[8*i +: 8] = raw[8*(int'(nb)-1-i) +: 8];
                else      lane[8*i +: 8] = raw[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
#(
    parameter int RA_W  = 5,
    parameter int CNT_W = 16,
    parameter int NBUF  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            step,
    input  logic            step_buf,
    input  logic            fin,
    input  logic            halted,
    output logic [31:0]     mode_o,
    output logic [31:0]     fifo_o,
    output logic [31:0]     mem0_o,
    output logic [31:0]     mem1_o,
    output logic            zero0_o,
    output logic            zero1_o
);
    localparam int WI_W = RA_W - 2;

    logic [WI_W-1:0]  widx;
    logic [31:0]      mode_q, mode_d, fifo_q;
    logic [31:0]      addr_q [NBUF];
    logic [CNT_W-1:0] cnt_q  [NBUF];
    logic [31:0]      step_inc;

    assign widx     = reg_addr[RA_W-1:2];
    assign step_inc = 32'(item_bytes(mode_q[MB_DW_LO +: 2]));

    always_comb begin
        int act;
        act    = int'(mode_q[MB_ACT]);
        mode_d = mode_q;
        if (fin) begin
            mode_d[MB_DN0 + 2*act] = 1'b1;
            mode_d[MB_EN0 + 2*act] = 1'b0;
            mode_d[MB_ACT]         = ~mode_q[MB_ACT];
        end
        if (reg_we && int'(widx) == WI_SET) mode_d = mode_d | (reg_wdata & MODE_RW_MASK);
        if (reg_we && int'(widx) == WI_CLR) mode_d = mode_d & ~(reg_wdata & MODE_RW_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            fifo_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (reg_we && int'(widx) == WI_FIFO) fifo_q <= reg_wdata;
        end
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_desc
        localparam int A_IDX = WI_A0 + 2*b;
        localparam int C_IDX = WI_C0 + 2*b;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[b] <= '0;
                cnt_q[b]  <= '0;
            end else begin
                if (reg_we && int'(widx) == A_IDX)   addr_q[b] <= reg_wdata;
                else if (step && int'(step_buf) == b) addr_q[b] <= addr_q[b] + step_inc;
                if (reg_we && int'(widx) == C_IDX)   cnt_q[b]  <= reg_wdata[CNT_W-1:0];
                else if (step && int'(step_buf) == b) cnt_q[b]  <= cnt_q[b] - 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (int'(widx))
            WI_SET, WI_CLR: reg_rdata = mode_q | (32'(halted) << MB_HALT);
            WI_FIFO:        reg_rdata = fifo_q;
            WI_A0:          reg_rdata = addr_q[0];
            WI_C0:          reg_rdata = 32'(cnt_q[0]);
            WI_A0 + 2:      reg_rdata = addr_q[1];
            WI_C0 + 2:      reg_rdata = 32'(cnt_q[1]);
            default:        reg_rdata = '0;
        endcase
    end

    assign mode_o  = mode_q;
    assign fifo_o  = fifo_q;
    assign mem0_o  = addr_q[0];
    assign mem1_o  = addr_q[1];
    assign zero0_o = (cnt_q[0] == '0);
    assign zero1_o = (cnt_q[1] == '0);
endmodule

// File: rtl/pp_dma_fsm.sv
module pp_dma_fsm
    import pp_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        act,
    input  logic        en0,
    input  logic        en1,
    input  logic        zero0,
    input  logic        zero1,
    input  logic        dir_p2m,
    input  logic [31:0] mem0,
    input  logic [31:0] mem1,
    input  logic [31:0] fifo,
    input  logic        per_req,
    input  logic        bus_ack,
    input  logic [31:0] lane_data,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    output logic        per_ack,
    output logic        step,
    output logic        step_buf,
    output logic        fin,
    output logic        halted
);
    dma_state_e  state_q, state_d;
    logic [31:0] src_q, dst_q, data_q;
    logic        buf_q;
    logic        act_en, act_zero;
    logic [31:0] act_mem;

    assign act_en   = act ? en1 : en0;
    assign act_zero = act ? zero1 : zero0;
    assign act_mem  = act ? mem1 : mem0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go && act_en) begin
                           if (act_zero)     state_d = ST_SWITCH;
                           else if (per_req) state_d = ST_FETCH;
                       end
            ST_SWITCH: state_d = ST_IDLE;
            ST_FETCH:  if (bus_ack) state_d = ST_STORE;
            ST_STORE:  if (bus_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            data_q <= '0;
            buf_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_FETCH) begin
                buf_q <= act;
                src_q <= dir_p2m ? fifo : act_mem;
                dst_q <= dir_p2m ? act_mem : fifo;
            end
            if (state_q == ST_FETCH && bus_ack) data_q <= lane_data;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        per_ack   = 1'b0;
        step      = 1'b0;
        fin       = 1'b0;
        halted    = 1'b0;
        unique case (state_q)
            ST_IDLE:   halted = ~go;
            ST_SWITCH: fin = 1'b1;
            ST_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = src_q;
            end
            ST_STORE: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = dst_q;
                bus_wdata = data_q;
                per_ack   = bus_ack;
                step      = bus_ack;
            end
            default: ;
        endcase
    end

    assign step_buf = buf_q;
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int RA_W  = 5,
    parameter int CNT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            per_req,
    output logic            per_ack,
    output logic            bus_req,
    output logic            bus_we,
    output logic [31:0]     bus_addr,
    output logic [31:0]     bus_wdata,
    input  logic [31:0]     bus_rdata,
    input  logic            bus_ack,
    output logic            irq
);
    logic [31:0] mode_w, fifo_w, mem0_w, mem1_w, lane_w;
    logic        zero0_w, zero1_w, step_w, step_buf_w, fin_w, halted_w;
    logic        go_w, dn0_w, dn1_w;

    assign go_w  = mode_w[MB_GO];
    assign dn0_w = mode_w[MB_DN0];
    assign dn1_w = mode_w[MB_DN1];

    pp_dma_regs #(.RA_W(RA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step(step_w),
        .step_buf(step_buf_w), .fin(fin_w), .halted(halted_w),
        .mode_o(mode_w), .fifo_o(fifo_w), .mem0_o(mem0_w), .mem1_o(mem1_w),
        .zero0_o(zero0_w), .zero1_o(zero1_w)
    );

    pp_dma_lane #(.DATA_W(32)) u_lane (
        .raw(bus_rdata), .width_code(mode_w[MB_DW_LO +: 2]),
        .swap(mode_w[MB_SWAP]), .lane(lane_w)
    );

    pp_dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go_w), .act(mode_w[MB_ACT]),
        .en0(mode_w[MB_EN0]), .en1(mode_w[MB_EN1]), .zero0(zero0_w),
        .zero1(zero1_w), .dir_p2m(mode_w[MB_DIR]), .mem0(mem0_w),
        .mem1(mem1_w), .fifo(fifo_w), .per_req(per_req), .bus_ack(bus_ack),
        .lane_data(lane_w), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .per_ack(per_ack),
        .step(step_w), .step_buf(step_buf_w), .fin(fin_w), .halted(halted_w)
    );

    assign irq = mode_w[MB_IE] & (dn0_w | dn1_w);
endmodule

// File: rtl/pp_dma_chan_chk.sv
module pp_dma_chan_chk #(
    parameter int RA_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic [RA_W-1:0] reg_addr,
    input logic [31:0]     reg_wdata,
    input logic            per_ack,
    input logic            bus_req,
    input logic            bus_we,
    input logic [31:0]     bus_addr,
    input logic            bus_ack,
    input logic            halted,
    input logic            done0
);
    logic clr_dn0;
    assign clr_dn0 = reg_we && (reg_addr[RA_W-1:2] == 1) && reg_wdata[1];

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R4
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && !bus_we |=> bus_req && bus_we); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack); // R12
    AST_ACK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> bus_req && bus_we && bus_ack); // R12
    AST_NO_HALT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !halted); // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done0 && !clr_dn0 |=> done0); // R10
endmodule

bind pp_dma_chan pp_dma_chan_chk #(.RA_W(RA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .per_ack(per_ack), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .halted(halted_w), .done0(dn0_w)
);

// File: tb/test_pp_dma_chan.sv
`timescale 1ns/1ps
module test_pp_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    localparam logic [31:0] RW_MASK = 32'h000F_BFBF;

    logic [31:0] exp_mode = '0;
    logic [31:0] exp_addr [2];
    int          exp_cnt  [2];
    logic [31:0] fifo_a;

    always #5 clk = ~clk;

    pp_dma_chan i_pp_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_ack(per_ack), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_exp(input logic [31:0] d, input int dw, input bit sw);
        if (dw == 0) return {24'b0, d[7:0]};
        if (dw == 1) return sw ? {16'b0, d[7:0], d[15:8]} : {16'b0, d[15:0]};
        return sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endfunction

    function automatic logic [31:0] mode_view();
        return exp_mode | (exp_mode[5] ? 32'h0 : 32'h40);
    endfunction

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 5'h00) exp_mode = exp_mode | (d & RW_MASK);
        if (a == 5'h04) exp_mode = exp_mode & ~(d & RW_MASK);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic serve_beat(input bit exp_we, input logic [31:0] exp_a, input logic [31:0] rd_val);
        for (int w = 0; w < 60 && !bus_req; w++) @(negedge clk);
        chk(bus_req == 1'b1, "R4 beat issued", 32'(bus_req), 1);
        chk(bus_we == exp_we, "R4 beat kind", 32'(bus_we), 32'(exp_we));
        chk(bus_addr == exp_a, "R4 beat address", bus_addr, exp_a);
        if (exp_we) chk(bus_wdata == rd_val, "R11 write data", bus_wdata, rd_val);
        repeat ($urandom % 3) @(negedge clk);
        bus_rdata = exp_we ? 32'h0 : rd_val;
        bus_ack = 1'b1;
        #1;
        if (exp_we) chk(per_ack == 1'b1, "R12 ack pulse", 32'(per_ack), 1);
        else        chk(per_ack == 1'b0, "R12 no ack on read", 32'(per_ack), 0);
        @(negedge clk);
        bus_ack = 1'b0;
        if (exp_we) chk(per_ack == 1'b0, "R12 ack single cycle", 32'(per_ack), 0);
    endtask

    task automatic do_item(input bit stop_mid);
        int          b;
        logic [31:0] rd, mem, src, dst, v;
        int          dw;
        bit          dir, sw;
        b   = int'(exp_mode[4]);
        dw  = int'(exp_mode[10:9]);
        dir = exp_mode[12];
        sw  = exp_mode[13];
        mem = exp_addr[b];
        rd  = $urandom;
        src = dir ? fifo_a : mem;
        dst = dir ? mem : fifo_a;
        per_req = 1'b1;
        if (stop_mid) begin
            for (int w = 0; w < 60 && !bus_req; w++) @(negedge clk);
            reg_wr(5'h04, 32'h20);
            reg_rd(5'h00, v);
            chk(v == exp_mode, "R9 no halt while item in flight", v, exp_mode);
        end
        serve_beat(1'b0, src, rd);
        serve_beat(1'b1, dst, lane_exp(rd, dw, sw));
        per_req = 1'b0;
        exp_addr[b] = exp_addr[b] + ((dw == 0) ? 1 : (dw == 1) ? 2 : 4);
        exp_cnt[b]--;
        if (exp_cnt[b] == 0) begin
            exp_mode[1 + 2*b] = 1'b1;
            exp_mode[2*b]     = 1'b0;
            exp_mode[4]       = ~exp_mode[4];
        end
    endtask

    task automatic program_run(input int n_act, input int n_oth, input bit en_oth);
        int b, o, dw;
        bit dir, sw;
        logic [31:0] setw;
        b   = int'(exp_mode[4]);
        o   = 1 - b;
        dw  = int'($urandom % 3);
        dir = 1'($urandom);
        sw  = 1'($urandom);
        fifo_a = {$urandom} & 32'hFFFF_FFFC;
        exp_addr[b] = {$urandom} & 32'h7FFF_FFF0;
        exp_addr[o] = {$urandom} & 32'h7FFF_FFF0;
        exp_cnt[b] = n_act;
        exp_cnt[o] = n_oth;
        reg_wr(5'h08, fifo_a);
        reg_wr(5'(12 + 8*b), exp_addr[b]);
        reg_wr(5'(16 + 8*b), 32'(n_act));
        reg_wr(5'(12 + 8*o), exp_addr[o]);
        reg_wr(5'(16 + 8*o), 32'(n_oth));
        reg_wr(5'h04, 32'h000F_3600);
        setw = (32'(dw) << 9) | (32'(dir) << 12) | (32'(sw) << 13) | 32'h80 | 32'h20
             | (32'h1 << (2*b)) | (en_oth ? (32'h1 << (2*o)) : 32'h0)
             | (32'($urandom % 16) << 16);
        reg_wr(5'h00, setw);
    endtask

    task automatic run_case(input int n_act, input int n_oth, input bit en_oth);
        logic [31:0] v;
        int b0;
        b0 = int'(exp_mode[4]);
        program_run(n_act, n_oth, en_oth);
        for (int k = 0; k < n_act + (en_oth ? n_oth : 0); k++) do_item(1'b0);
        repeat (3) @(negedge clk);
        reg_rd(5'h00, v);
        chk(v == mode_view(), "R6 done/enable/active after drain", v, mode_view());
        reg_rd(5'(16 + 8*b0), v);
        chk(v == 0, "R5 count reached zero", v, 0);
        reg_rd(5'(12 + 8*b0), v);
        chk(v == exp_addr[b0], "R5 address advanced", v, exp_addr[b0]);
        chk(irq == 1'b1, "R8 irq with done and enable", 32'(irq), 1);
        if (!en_oth) begin
            per_req = 1'b1;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                chk(bus_req == 1'b0, "R7 no bus while buffer disabled", 32'(bus_req), 0);
            end
            per_req = 1'b0;
            reg_rd(5'h00, v);
            chk(v == mode_view(), "R7 go kept, no halt", v, mode_view());
            reg_rd(5'(16 + 8*(1 - b0)), v);
            chk(v == 32'(n_oth), "R7 idle buffer count untouched", v, 32'(n_oth));
        end
        reg_wr(5'h00, 32'h0);
        reg_wr(5'h04, 32'h0);
        reg_rd(5'h00, v);
        chk(v[3:1] == mode_view()[3:1] && (v[1] | v[3]), "R10 zero writes keep done", v, mode_view());
        reg_wr(5'h04, 32'h0000_000A);
        reg_rd(5'h00, v);
        chk(v[3] == 1'b0 && v[1] == 1'b0, "R10 clear address removes done", v, mode_view());
        chk(irq == 1'b0, "R8 irq drops with done", 32'(irq), 0);
        reg_wr(5'h04, 32'h20);
        reg_rd(5'h00, v);
        chk(v[6] == 1'b1, "R9 halt after go cleared", v, mode_view());
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_rd(5'h00, v); chk(v == 32'h40, "R1 control word", v, 32'h40);
        reg_rd(5'h10, v); chk(v == 0, "R1 count0", v, 0);
        reg_rd(5'h14, v); chk(v == 0, "R1 addr1", v, 0);
        chk({bus_req, per_ack, irq} == 3'b000, "R1 outputs idle", 32'({bus_req, per_ack, irq}), 0);
        // R2 set/clear addresses and read-only bits
        reg_wr(5'h00, 32'hFFF0_46C0);
        reg_rd(5'h00, v); chk(v == 32'h6C0, "R2 set only writable", v, 32'h6C0);
        reg_wr(5'h04, 32'h0000_0080);
        reg_rd(5'h04, v); chk(v == 32'h640, "R2 clear named bit", v, 32'h640);
        reg_wr(5'h04, 32'hFFFF_FFFF);
        reg_rd(5'h00, v); chk(v == 32'h40, "R2 clear all", v, 32'h40);
        // R3 count width
        reg_wr(5'h18, 32'hABCD_1234);
        reg_rd(5'h18, v); chk(v == 32'h1234, "R3 count upper bits dropped", v, 32'h1234);
        // single buffer runs, then ping-pong runs
        for (int k = 0; k < 3; k++) run_case(1 + int'($urandom % 4), 5, 1'b0);
        for (int k = 0; k < 4; k++) run_case(1 + int'($urandom % 4), 1 + int'($urandom % 4), 1'b1);
        // R9 stop in the middle of an item, then resume
        program_run(2, 1, 1'b0);
        do_item(1'b1);
        @(negedge clk);
        reg_rd(5'h00, v); chk(v == mode_view() && v[6], "R9 halt once item retired", v, mode_view());
        reg_rd(5'(16 + 8*int'(exp_mode[4])), v); chk(v == 1, "R9 in-flight item counted", v, 1);
        reg_wr(5'h00, 32'h20);
        do_item(1'b0);
        repeat (3) @(negedge clk);
        reg_rd(5'h00, v); chk(v == mode_view(), "R6 resumed buffer retired", v, mode_view());
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule